// File: doc/BRIEF.md
# Sequential Signed Integer Divider

The block divides one two's complement integer by another of the same width over several clock cycles. It computes a quotient that truncates toward zero and a remainder that carries the dividend's sign, so that dividend = quotient × divisor + remainder holds in N-bit arithmetic. A one-cycle request on `start_i` loads the operands. `busy_o` stays high while the iterations run. `done_o` then pulses for one cycle with the results on the output ports, and those outputs hold until the next completion.

Inside, the divisor is held sign-extended in a register. The dividend sits in a double register: its upper part is the sign extension of the dividend and its lower part is the dividend itself. Each iteration shifts that pair left by one bit and moves the upper part toward zero by the divisor. The divisor is subtracted when its sign matches the dividend's sign and added otherwise. When the trial keeps the dividend's sign, it is kept and a quotient bit of 1 enters at the bottom. Otherwise the upper part is restored and a 0 enters. A trial that reaches exactly zero counts as kept for a non-negative dividend. For a negative dividend it counts as kept only when every dividend bit not yet shifted out is zero. After N iterations the upper part is the remainder. The collected bits form the quotient's magnitude, which is negated when the operand signs differ.

A zero divisor skips the iterations, raises a divide-by-zero flag, and returns zero for both results.

Top module: `sdiv_restoring`

## Requirements
- R1: A `start_i` sampled high while `busy_o` is low, with a nonzero divisor, makes `done_o` high exactly N+1 clock cycles after that edge. `busy_o` is high from the cycle after the start edge until `done_o` rises, and it is low whenever `done_o` is high.
- R2: For every nonzero divisor, `quotient_o` equals the mathematical quotient truncated toward zero, taken modulo 2^N.
- R3: `remainder_o` satisfies dividend = quotient × divisor + remainder (mod 2^N). A nonzero remainder has the dividend's sign, and its magnitude is less than the divisor's.
- R4: The quotient is negative exactly when the operand signs differ and the quotient is nonzero. For example, 7 / -3 gives quotient -2 and remainder 1, and -7 / 3 gives quotient -2 and remainder -1.
- R5: A zero divisor raises `div_zero_o` together with `done_o` two cycles after the start edge, and `quotient_o` and `remainder_o` are both zero.
- R6: `done_o` is high for exactly one cycle per accepted request. `quotient_o`, `remainder_o` and `div_zero_o` hold their values until the next `done_o`.
- R7: `start_i` is ignored while `busy_o` is high. The running division finishes with its own operands, and no second completion follows.
- R8: The most negative value divided by -1 returns the most negative value as the quotient (wrap-around) and zero as the remainder.
- R9: After reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all low.
- R10: `div_zero_o` is low at the completion of any request whose divisor is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division with the present operands |
| dividend_i | input | N | Signed dividend |
| divisor_i | input | N | Signed divisor |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | The completed request had a zero divisor |
| quotient_o | output | N | Signed quotient, truncated toward zero |
| remainder_o | output | N | Signed remainder, sign of the dividend |

## Verification
A wrong keep-or-restore decision in any single iteration corrupts one quotient bit and shifts the partial remainder. That error shows at the next `done_o` as a quotient and remainder that break the identity dividend = quotient × divisor + remainder, or as a remainder with the wrong sign or size. The signed corner cases are where the zero-trial rule and the final negation can go wrong: a negative dividend whose remainder is zero, and the most negative operands. An exhaustive sweep at a small width therefore reaches all of them. A miscounted iteration counter shows as `done_o` arriving on the wrong cycle, which is visible at the first request.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    // Sequencer states of the divider
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ZERO = 2'd2
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_load.sv
// Operand preparation: sign extension of the dividend into the upper half,
// sign extension of the divisor, and the sign facts the iterations need.
module sdiv_load #(
    parameter int N = 32
) (
    input  logic [N-1:0] dividend_i,
    input  logic [N-1:0] divisor_i,
    output logic [N:0]   a_init_o,
    output logic [N-1:0] q_init_o,
    output logic [N:0]   m_ext_o,
    output logic         dsign_o,
    output logic         neg_o,
    output logic         is_zero_o
);
    localparam int AW = N + 1;

    always_comb begin
        a_init_o  = {AW{dividend_i[N-1]}};
        q_init_o  = dividend_i;
        m_ext_o   = {divisor_i[N-1], divisor_i};
        dsign_o   = dividend_i[N-1];
        neg_o     = dividend_i[N-1] ^ divisor_i[N-1];
        is_zero_o = (divisor_i == '0);
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring iteration: shift the A,Q pair, try moving A toward zero by
// the divisor, keep or restore, and shift in the quotient bit.
module sdiv_step #(
    parameter int N  = 32,
    parameter int CW = 6
) (
    input  logic [N:0]    a_i,
    input  logic [N-1:0]  q_i,
    input  logic [N:0]    m_i,
    input  logic          dsign_i,
    input  logic [CW-1:0] iter_i,
    output logic [N:0]    a_o,
    output logic [N-1:0]  q_o
);
    localparam int AW = N + 1;

    logic [AW-1:0] a_sh;
    logic [N-1:0]  q_sh;
    logic [AW-1:0] trial;
    logic [N-1:0]  pending;
    logic          toward_zero_sub;
    logic          keep;

    always_comb begin
        a_sh = (a_i << 1) | AW'(q_i[N-1]);
        q_sh = q_i << 1;

        // Subtract when divisor and partial remainder share a sign.
        toward_zero_sub = (dsign_i == m_i[AW-1]);
        if (toward_zero_sub) begin
            trial = a_sh - m_i;
        end else begin
            trial = a_sh + m_i;
        end

        // Dividend bits still waiting in Q after this shift.
        pending = q_sh >> (int'(iter_i) + 1);

        if (dsign_i) begin
            keep = trial[AW-1] || ((trial == '0) && (pending == '0));
        end else begin
            keep = !trial[AW-1];
        end

        a_o = keep ? trial : a_sh;
        q_o = {q_sh[N-1:1], keep};
    end
endmodule

// File: rtl/sdiv_fixup.sv
// Final sign correction of the quotient and extraction of the remainder.
module sdiv_fixup #(
    parameter int N = 32
) (
    input  logic [N-1:0] q_mag_i,
    input  logic [N-1:0] a_low_i,
    input  logic         neg_i,
    output logic [N-1:0] quo_o,
    output logic [N-1:0] rem_o
);
    always_comb begin
        quo_o = neg_i ? ('0 - q_mag_i) : q_mag_i;
        rem_o = a_low_i;
    end
endmodule

// File: rtl/sdiv_restoring.sv
module sdiv_restoring #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [N-1:0] dividend_i,
    input  logic [N-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         div_zero_o,
    output logic [N-1:0] quotient_o,
    output logic [N-1:0] remainder_o
);
    import sdiv_pkg::*;

    localparam int AW = N + 1;
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);

    typedef struct packed {
        sdiv_state_e   st;
        logic [AW-1:0] a;
        logic [N-1:0]  q;
        logic [AW-1:0] m;
        logic          dsign;
        logic          neg;
        logic [CW-1:0] iter;
        logic          done;
        logic          dz;
        logic [N-1:0]  quo;
        logic [N-1:0]  rem;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] ld_a, ld_m, st_a;
    logic [N-1:0]  ld_q, st_q, fx_quo, fx_rem;
    logic          ld_dsign, ld_neg, ld_zero;

    sdiv_load #(.N(N)) u_load (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .a_init_o   (ld_a),
        .q_init_o   (ld_q),
        .m_ext_o    (ld_m),
        .dsign_o    (ld_dsign),
        .neg_o      (ld_neg),
        .is_zero_o  (ld_zero)
    );

    sdiv_step #(.N(N), .CW(CW)) u_step (
        .a_i     (r_q.a),
        .q_i     (r_q.q),
        .m_i     (r_q.m),
        .dsign_i (r_q.dsign),
        .iter_i  (r_q.iter),
        .a_o     (st_a),
        .q_o     (st_q)
    );

    sdiv_fixup #(.N(N)) u_fixup (
        .q_mag_i (st_q),
        .a_low_i (st_a[N-1:0]),
        .neg_i   (r_q.neg),
        .quo_o   (fx_quo),
        .rem_o   (fx_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.a     = ld_a;
                    r_d.q     = ld_q;
                    r_d.m     = ld_m;
                    r_d.dsign = ld_dsign;
                    r_d.neg   = ld_neg;
                    r_d.iter  = '0;
                    r_d.st    = ld_zero ? ST_ZERO : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.a    = st_a;
                r_d.q    = st_q;
                r_d.iter = r_q.iter + 1'b1;
                if (r_q.iter == LAST_ITER) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.dz   = 1'b0;
                    r_d.quo  = fx_quo;
                    r_d.rem  = fx_rem;
                end
            end
            ST_ZERO: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.dz   = 1'b1;
                r_d.quo  = '0;
                r_d.rem  = '0;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign div_zero_o  = r_q.dz;
    assign quotient_o  = r_q.quo;
    assign remainder_o = r_q.rem;
endmodule

// File: rtl/sdiv_restoring_chk.sv
module sdiv_restoring_chk #(
    parameter int N = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         start_i,
    input logic [N-1:0] dividend_i,
    input logic [N-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         div_zero_o,
    input logic [N-1:0] quotient_o,
    input logic [N-1:0] remainder_o
);
    logic [N-1:0] cap_dvd, cap_dvs;
    logic [31:0]  lat;
    logic [N-1:0] recon;
    logic [N-1:0] rem_mag, dvs_mag;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_dvd <= '0;
            cap_dvs <= '0;
            lat     <= '0;
        end else if (start_i && !busy_o) begin
            cap_dvd <= dividend_i;
            cap_dvs <= divisor_i;
            lat     <= 32'd1;
        end else if (busy_o) begin
            lat <= lat + 32'd1;
        end
    end

    assign recon   = quotient_o * cap_dvs + remainder_o;
    assign rem_mag = remainder_o[N-1] ? ('0 - remainder_o) : remainder_o;
    assign dvs_mag = cap_dvs[N-1] ? ('0 - cap_dvs) : cap_dvs;

    assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (lat == (div_zero_o ? 32'd2 : 32'(N + 1))));

    assert_idle_at_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_identity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o) |-> (recon == cap_dvd));

    assert_rem_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o && remainder_o != '0) |->
            (remainder_o[N-1] == cap_dvd[N-1]));

    assert_rem_small_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o && cap_dvs != {1'b1, {(N-1){1'b0}}}) |->
            (rem_mag < dvs_mag));

    assert_zero_results_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && div_zero_o) |-> (quotient_o == '0 && remainder_o == '0));

    assert_flag_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (div_zero_o == (cap_dvs == '0)));

    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

bind sdiv_restoring sdiv_restoring_chk #(.N(N)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .div_zero_o  (div_zero_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/sdiv_restoring_bench.sv
module sdiv_restoring_bench;
    localparam int N          = 6;
    localparam int CLK_PERIOD = 10;
    localparam int MINV       = -(1 << (N - 1));
    localparam int MAXV       = (1 << (N - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] dvd = '0;
    logic [N-1:0] dvs = '0;
    logic         busy, done, dz;
    logic [N-1:0] quo, rem;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] got_q, got_r;
    logic         got_dz;
    int           got_lat;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdiv_restoring #(.N(N)) u_sdiv_restoring (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .busy_o      (busy),
        .done_o      (done),
        .div_zero_o  (dz),
        .quotient_o  (quo),
        .remainder_o (rem)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_quo(input int a, input int b);
        int t;
        if (b == 0) return '0;
        t = a / b;
        return t[N-1:0];
    endfunction

    function automatic logic [N-1:0] exp_rem(input int a, input int b);
        int t;
        if (b == 0) return '0;
        t = a % b;
        return t[N-1:0];
    endfunction

    // Issue one request and wait for completion; inputs change at negedge.
    task automatic do_div(input int a, input int b);
        @(negedge clk);
        dvd   = a[N-1:0];
        dvs   = b[N-1:0];
        start = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        got_lat = 0;
        for (int i = 1; i <= N + 8; i++) begin
            if (done) begin
                got_lat = i;
                break;
            end
            @(negedge clk);
        end
        got_q  = quo;
        got_r  = rem;
        got_dz = dz;
    endtask

    task automatic t_reset();
        check(!busy && !done && !dz, "R9 control outputs after reset", int'({busy, done, dz}), 0);
        check(quo == '0 && rem == '0, "R9 data outputs after reset", int'({quo, rem}), 0);
    endtask

    task automatic t_examples();
        int pairs [4][2] = '{'{7, -3}, '{-7, 3}, '{7, 3}, '{-7, -3}};
        for (int k = 0; k < 4; k++) begin
            int a = pairs[k][0];
            int b = pairs[k][1];
            do_div(a, b);
            check(got_q == exp_quo(a, b), "R4 quotient sign", int'(got_q), int'(exp_quo(a, b)));
            check(got_r == exp_rem(a, b), "R4 remainder sign", int'(got_r), int'(exp_rem(a, b)));
        end
    endtask

    task automatic t_latency();
        int busy_bad = 0;
        @(negedge clk);
        dvd = 6'd25; dvs = 6'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= N; i++) begin
            if (!busy || done) busy_bad++;
            @(negedge clk);
        end
        check(busy_bad == 0, "R1 busy high during iterations", busy_bad, 0);
        check(done && !busy, "R1 done after N+1 cycles", int'({done, busy}), 2);
        check(quo == 6'd6 && rem == 6'd1, "R1 result 25/4", int'({quo, rem}), int'({6'd6, 6'd1}));
    endtask

    task automatic t_zero();
        do_div(-13, 0);
        check(got_lat == 2, "R5 zero divisor latency", got_lat, 2);
        check(got_dz == 1'b1, "R5 zero flag", int'(got_dz), 1);
        check(got_q == '0 && got_r == '0, "R5 zero results", int'({got_q, got_r}), 0);
        do_div(9, 2);
        check(got_dz == 1'b0, "R10 flag clears on nonzero divisor", int'(got_dz), 0);
    endtask

    task automatic t_hold();
        int bad = 0;
        do_div(-29, 5);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done || quo != exp_quo(-29, 5) || rem != exp_rem(-29, 5)) bad++;
        end
        check(bad == 0, "R6 single pulse and held results", bad, 0);
    endtask

    task automatic t_ignore();
        int extra = 0;
        @(negedge clk);
        dvd = 6'd13; dvs = 6'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dvd = 6'(-20); dvs = 6'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dvd = '0; dvs = '0;
        while (!done) @(negedge clk);
        check(quo == 6'd3 && rem == 6'd1, "R7 running request unaffected", int'({quo, rem}), int'({6'd3, 6'd1}));
        for (int i = 0; i < N + 4; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check(extra == 0, "R7 no second completion", extra, 0);
    endtask

    task automatic t_wrap();
        do_div(MINV, -1);
        check(got_q == exp_quo(MINV, -1), "R8 most negative by -1 quotient", int'(got_q), int'(exp_quo(MINV, -1)));
        check(got_r == '0, "R8 most negative by -1 remainder", int'(got_r), 0);
        do_div(MINV, MINV);
        check(got_q == 6'd1 && got_r == '0, "R8 most negative by itself", int'({got_q, got_r}), int'({6'd1, 6'd0}));
    endtask

    task automatic t_sweep();
        int bad_q = 0, bad_r = 0, bad_f = 0;
        for (int a = MINV; a <= MAXV; a++) begin
            for (int b = MINV; b <= MAXV; b++) begin
                do_div(a, b);
                if (got_q != exp_quo(a, b)) begin
                    bad_q++;
                    check(1'b0, "R2 quotient", int'(got_q), int'(exp_quo(a, b)));
                end
                if (got_r != exp_rem(a, b)) begin
                    bad_r++;
                    check(1'b0, "R3 remainder", int'(got_r), int'(exp_rem(a, b)));
                end
                if (got_dz != (b == 0)) begin
                    bad_f++;
                    check(1'b0, "R10 zero flag", int'(got_dz), int'(b == 0));
                end
            end
        end
        check(bad_q == 0, "R2 sweep quotient mismatches", bad_q, 0);
        check(bad_r == 0, "R3 sweep remainder mismatches", bad_r, 0);
        check(bad_f == 0, "R10 sweep flag mismatches", bad_f, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_latency();
        t_zero();
        t_hold();
        t_ignore();
        t_wrap();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule